// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block serves read requests for a single DRAM bank. It records which row, if any, sits in the bank's row buffer. For each accepted request it classifies the access against that row as a hit, a miss or a conflict. It then issues the matching command chain: read alone; activate then read; or precharge, activate, then read. The programmed gaps between commands come from three cycle counts: precharge-to-activate, activate-to-read and read-to-data.

Only one request is in flight at a time. The requester sees ready drop from acceptance until the bank can take new work. When the read latency has run out, the block returns a one-cycle response with the request's row, column and access class. A policy input, sampled per request, selects one of two behaviours after the read:
- Leave the row open, so that later accesses to the same row are fast.
- Close the row at once with an automatic precharge, so that every following access starts from an idle bank.

Top module: `dram_bank_seq`

## Requirements
- R1: When the requested row is the open row, the only command is a read (code 2'b11, address = zero-extended column), and the response follows tCAS cycles after it with class hit (2'b00).
- R2: When no row is open, an activate (code 2'b10, address = row) is issued, then a read tRCD cycles later, then the response tCAS cycles after the read, with class miss (2'b01).
- R3: When another row is open, a precharge (code 2'b01, address = the row being closed) is issued, then an activate tRP cycles later, then a read tRCD cycles later, then the response tCAS cycles after that, with class conflict (2'b10). For the row order A, B, A, the second and third requests are both conflicts.
- R4: With the open-page policy (policy input 0), the row stays open after the response, and ready returns in the cycle after the response.
- R5: With the closed-page policy (policy input 1), a precharge of the accessed row is issued in the response cycle. Ready returns tRP+1 cycles after that precharge, and the next access is a miss.
- R6: After reset, ready is high, no command or response is driven, and no row counts as open.
- R7: Ready is low from the cycle after acceptance until the bank can take a request again. A valid request held while ready is low has no effect. Policy and timing inputs are sampled only at acceptance.
- R8: A command strobe lasts one cycle per command and is valid only when a command issues. The first command of a request issues in the cycle after acceptance. The code 2'b00 means no command.
- R9: The response valid is a single-cycle pulse carrying the accepted request's row, column and class.
- R10: A timing input of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_row_i | input | ROW_W | Requested row |
| req_col_i | input | COL_W | Requested column |
| close_page_i | input | 1 | 1 selects closed-page policy for this request |
| t_rp_i | input | TW | Precharge-to-activate cycles |
| t_rcd_i | input | TW | Activate-to-read cycles |
| t_cas_i | input | TW | Read-to-data cycles |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_o | output | 2 | Command code |
| cmd_addr_o | output | max(ROW_W,COL_W) | Row for precharge/activate, column for read |
| rsp_valid_o | output | 1 | Read complete |
| rsp_row_o | output | ROW_W | Row of the completed request |
| rsp_col_o | output | COL_W | Column of the completed request |
| rsp_class_o | output | 2 | Access class: hit, miss or conflict |

## Verification
The bench targets three areas:
- **Ping-pong between two rows.** A tracker that misses a row change would emit a bare read where a precharge belongs. A tracker that forgets the old row would report a miss instead of a conflict.
- **Policy switch from open to closed on a hit.** This exposes an automatic precharge that is missing, issued late or given the wrong row. It also exposes a ready that comes back before tRP has run out.
- **Zero and unit timing values mixed with timing inputs that change while busy.** A counter that underflows on 0, that is off by one, or that re-reads live inputs would shift command cycles away from where the reference model places them.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_PRE = 2'b01,
    CMD_ACT = 2'b10,
    CMD_RD  = 2'b11
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ACC_HIT      = 2'b00,
    ACC_MISS     = 2'b01,
    ACC_CONFLICT = 2'b10
  } acc_class_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_ACT,
    PH_RD,
    PH_DATA,
    PH_CLOSE
  } seq_phase_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  // a gap of v cycles: zero is reached v cycles after the load; 0 acts as 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (val_i == '0) ? '0 : val_i - TW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

  a_r10_min_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (expired_o == ($past(val_i) <= TW'(1))));
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  dram_cmd_e        cmd_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic [ROW_W-1:0] probe_row_i,
  output logic             open_vld_o,
  output logic [ROW_W-1:0] open_row_o,
  output acc_class_e       class_o
);
  logic             vld_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else if (cmd_valid_i) begin
      if (cmd_i == CMD_ACT) begin
        vld_q <= 1'b1;
        row_q <= act_row_i;
      end else if (cmd_i == CMD_PRE) begin
        vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!vld_q)                    class_o = ACC_MISS;
    else if (row_q == probe_row_i) class_o = ACC_HIT;
    else                           class_o = ACC_CONFLICT;
  end

  assign open_vld_o = vld_q;
  assign open_row_o = row_q;

  a_r3_pre_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_PRE) |-> vld_q);
  a_r2_act_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_ACT) |-> !vld_q);
  a_r1_rd_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_RD) |-> vld_q);
endmodule

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TW    = 8,
  parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             close_page_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_cas_i,
  input  acc_class_e       class_i,
  input  logic             open_vld_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic [TW-1:0]    tmr_val_o,
  output logic             cmd_valid_o,
  output dram_cmd_e        cmd_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic [ROW_W-1:0] cur_row_o,
  output logic             rsp_valid_o,
  output logic [ROW_W-1:0] rsp_row_o,
  output logic [COL_W-1:0] rsp_col_o,
  output acc_class_e       rsp_class_o
);
  seq_phase_e       phase_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             cp_q;
  logic [TW-1:0]    rp_q, rcd_q, cas_q;
  acc_class_e       cls_q;
  logic             accept;
  seq_phase_e       first_phase;

  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    unique case (class_i)
      ACC_HIT:  first_phase = PH_RD;
      ACC_MISS: first_phase = PH_ACT;
      default:  first_phase = PH_PRE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      cp_q    <= 1'b0;
      rp_q    <= '0;
      rcd_q   <= '0;
      cas_q   <= '0;
      cls_q   <= ACC_HIT;
    end else if (accept) begin
      phase_q <= first_phase;
      row_q   <= req_row_i;
      col_q   <= req_col_i;
      cp_q    <= close_page_i;
      rp_q    <= t_rp_i;
      rcd_q   <= t_rcd_i;
      cas_q   <= t_cas_i;
      cls_q   <= class_i;
    end else if (tmr_exp_i) begin
      unique case (phase_q)
        PH_PRE:   phase_q <= PH_ACT;
        PH_ACT:   phase_q <= PH_RD;
        PH_RD:    phase_q <= PH_DATA;
        PH_DATA:  phase_q <= cp_q ? PH_CLOSE : PH_IDLE;
        PH_CLOSE: phase_q <= PH_IDLE;
        default:  phase_q <= phase_q;
      endcase
    end
  end

  // timer: a one-cycle lead-in after accept, then the gap after each command
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = TW'(1);
    if (accept) begin
      tmr_load_o = 1'b1;
    end else if (tmr_exp_i) begin
      unique case (phase_q)
        PH_PRE:  begin tmr_load_o = 1'b1; tmr_val_o = rp_q;  end
        PH_ACT:  begin tmr_load_o = 1'b1; tmr_val_o = rcd_q; end
        PH_RD:   begin tmr_load_o = 1'b1; tmr_val_o = cas_q; end
        PH_DATA: begin tmr_load_o = cp_q; tmr_val_o = rp_q;  end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_o       = CMD_NOP;
    cmd_addr_o  = '0;
    if (tmr_exp_i) begin
      unique case (phase_q)
        PH_PRE: begin
          cmd_valid_o = 1'b1; cmd_o = CMD_PRE; cmd_addr_o = AW'(open_row_i);
        end
        PH_ACT: begin
          cmd_valid_o = 1'b1; cmd_o = CMD_ACT; cmd_addr_o = AW'(row_q);
        end
        PH_RD: begin
          cmd_valid_o = 1'b1; cmd_o = CMD_RD;  cmd_addr_o = AW'(col_q);
        end
        PH_DATA: if (cp_q) begin
          cmd_valid_o = 1'b1; cmd_o = CMD_PRE; cmd_addr_o = AW'(row_q);
        end
        default: ;
      endcase
    end
  end

  assign rsp_valid_o = tmr_exp_i && (phase_q == PH_DATA);
  assign rsp_row_o   = row_q;
  assign rsp_col_o   = col_q;
  assign rsp_class_o = cls_q;
  assign cur_row_o   = row_q;

  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r9_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r4_open_row_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !cp_q) |=> (open_vld_i && open_row_i == $past(row_q)));
  a_r5_close_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && cp_q) |=> !open_vld_i);
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TW    = 8,
  parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             close_page_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_cas_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic             rsp_valid_o,
  output logic [ROW_W-1:0] rsp_row_o,
  output logic [COL_W-1:0] rsp_col_o,
  output logic [1:0]       rsp_class_o
);
  dram_cmd_e        cmd;
  acc_class_e       cls, rsp_cls;
  logic             open_vld;
  logic [ROW_W-1:0] open_row, cur_row;
  logic             tmr_exp, tmr_load;
  logic [TW-1:0]    tmr_val;

  bank_row_tracker #(.ROW_W(ROW_W)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_o),
    .cmd_i       (cmd),
    .act_row_i   (cur_row),
    .probe_row_i (req_row_i),
    .open_vld_o  (open_vld),
    .open_row_o  (open_row),
    .class_o     (cls)
  );

  seq_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  bank_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_row_i    (req_row_i),
    .req_col_i    (req_col_i),
    .close_page_i (close_page_i),
    .t_rp_i       (t_rp_i),
    .t_rcd_i      (t_rcd_i),
    .t_cas_i      (t_cas_i),
    .class_i      (cls),
    .open_vld_i   (open_vld),
    .open_row_i   (open_row),
    .tmr_exp_i    (tmr_exp),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd),
    .cmd_addr_o   (cmd_addr_o),
    .cur_row_o    (cur_row),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_row_o    (rsp_row_o),
    .rsp_col_o    (rsp_col_o),
    .rsp_class_o  (rsp_cls)
  );

  assign cmd_o       = cmd;
  assign rsp_class_o = rsp_cls;

  a_r8_strobe_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_o != 2'b00));
  a_r8_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o);
endmodule

// File: tb/tb_dram_bank_seq.sv
module tb_dram_bank_seq;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int TW    = 8;
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             close_page = 1'b0;
  logic [TW-1:0]    t_rp = 8'd1, t_rcd = 8'd1, t_cas = 8'd1;
  logic             cmd_valid;
  logic [1:0]       cmd;
  logic [AW-1:0]    cmd_addr;
  logic             rsp_valid;
  logic [ROW_W-1:0] rsp_row;
  logic [COL_W-1:0] rsp_col;
  logic [1:0]       rsp_class;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(req_row), .req_col_i(req_col), .close_page_i(close_page),
    .t_rp_i(t_rp), .t_rcd_i(t_rcd), .t_cas_i(t_cas),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_addr_o(cmd_addr),
    .rsp_valid_o(rsp_valid), .rsp_row_o(rsp_row), .rsp_col_o(rsp_col),
    .rsp_class_o(rsp_class)
  );

  always #5ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference model state
  bit             m_open = 1'b0;
  int             m_row = 0;
  int             ready_at = 0;
  logic [1:0]     e_cmd [int];
  logic [AW-1:0]  e_addr [int];
  string          e_tag [int];
  logic [25:0]    e_rsp [int];
  string          e_rtag [int];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic put_cmd(input int t, input logic [1:0] c, input int a, input string tag);
    e_cmd[t]  = c;
    e_addr[t] = AW'(a);
    e_tag[t]  = tag;
  endtask

  task automatic check_cycle();
    bit er;
    er = (cyc >= ready_at);
    chk(req_ready == er, "R7", "ready", longint'(req_ready), longint'(er));
    if (e_cmd.exists(cyc)) begin
      chk(cmd_valid && cmd == e_cmd[cyc] && cmd_addr == e_addr[cyc], e_tag[cyc], "cmd",
          longint'({cmd_valid, cmd, cmd_addr}), longint'({1'b1, e_cmd[cyc], e_addr[cyc]}));
      e_cmd.delete(cyc);
    end else begin
      chk(!cmd_valid, "R8", "stray cmd", longint'({cmd_valid, cmd, cmd_addr}), 0);
    end
    if (e_rsp.exists(cyc)) begin
      chk(rsp_valid && {rsp_row, rsp_col, rsp_class} == e_rsp[cyc], e_rtag[cyc], "rsp",
          longint'({rsp_valid, rsp_row, rsp_col, rsp_class}), longint'({1'b1, e_rsp[cyc]}));
      e_rsp.delete(cyc);
    end else begin
      chk(!rsp_valid, "R9", "stray rsp", longint'(rsp_valid), 0);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_cycle();
  endtask

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // schedule of one accepted request; s is the cycle of its first command
  task automatic model_accept(input int s, input int row, input int col, input bit cp,
                              input int rp_in, input int rcd_in, input int cas_in,
                              input string ovr);
    int t, rp, rcd, cas, cls;
    string tg;
    rp = clamp1(rp_in); rcd = clamp1(rcd_in); cas = clamp1(cas_in);
    t = s;
    if (m_open && m_row == row) cls = 0;
    else if (!m_open)           cls = 1;
    else                        cls = 2;
    tg = (cls == 0) ? "R1" : (cls == 1) ? "R2" : "R3";
    if (ovr != "") tg = ovr;
    if (cls == 2) begin put_cmd(t, 2'b01, m_row, tg); t += rp; end
    if (cls != 0) begin put_cmd(t, 2'b10, row, tg);   t += rcd; end
    put_cmd(t, 2'b11, col, tg);
    t += cas;
    e_rsp[t]  = {ROW_W'(row), COL_W'(col), 2'(cls)};
    e_rtag[t] = tg;
    if (cp) begin
      put_cmd(t, 2'b01, row, (ovr != "") ? ovr : "R5");
      ready_at = t + rp + 1;
      m_open   = 1'b0;
    end else begin
      ready_at = t + 1;
      m_open   = 1'b1;
      m_row    = row;
    end
  endtask

  // present a request (held while ready is low) until the model says accepted
  task automatic send(input int row, input int col, input bit cp,
                      input int rp, input int rcd, input int cas, input string ovr);
    req_row = ROW_W'(row); req_col = COL_W'(col); close_page = cp;
    t_rp = TW'(rp); t_rcd = TW'(rcd); t_cas = TW'(cas);
    req_valid = 1'b1;
    forever begin
      if (cyc >= ready_at) begin
        model_accept(cyc + 1, row, col, cp, rp, rcd, cas, ovr);
        tick();
        break;
      end
      tick();
    end
    req_valid = 1'b0;
    // junk on the sampled inputs while busy (R7)
    req_row = '1; req_col = '1; close_page = ~cp;
    t_rp = 8'd15; t_rcd = 8'd0; t_cas = 8'd9;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int lcg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    chk(req_ready == 1'b1, "R6", "ready after reset", longint'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R6", "cmd after reset", longint'(cmd_valid), 0);
    chk(rsp_valid == 1'b0, "R6", "rsp after reset", longint'(rsp_valid), 0);
    ready_at = cyc;
    idle(2);

    // first access finds no open row (R6 / R2)
    send(100, 3, 0, 3, 4, 2, "R6");
    idle(1);
    send(100, 7, 0, 3, 4, 2, "");      // R1 hit
    send(200, 9, 0, 3, 4, 2, "");      // R3 conflict, row A -> B
    send(100, 1, 0, 3, 4, 2, "");      // R3 conflict, back to A
    send(100, 2, 0, 2, 5, 6, "R4");    // open page kept row: hit, new timings
    send(100, 5, 1, 4, 2, 3, "");      // hit, then auto precharge (R5)
    send(100, 6, 0, 4, 2, 3, "R5");    // after close: miss
    send(300, 8, 1, 0, 0, 0, "R10");   // zero timings behave as 1
    send(300, 4, 1, 1, 1, 1, "R10");
    send(400, 1023, 0, 2, 2, 2, "");
    send(401, 0, 0, 1, 1, 1, "");

    lcg = 32'h1234;
    for (int k = 0; k < 40; k++) begin
      int row, col, rp, rcd, cas;
      bit cp;
      lcg = lcg * 1103515245 + 12345;
      row = 500 + ((lcg >>> 8) & 3);
      col = (lcg >>> 4) & 1023;
      cp  = (lcg >>> 13) & 1;
      rp  = (lcg >>> 16) & 7;
      rcd = (lcg >>> 19) & 7;
      cas = (lcg >>> 22) & 7;
      send(row, col, cp, rp, rcd, cas, "");
      if (((lcg >>> 26) & 3) == 0) idle(3);
    end

    idle(40);
    chk(e_cmd.size() == 0, "R8", "pending commands", longint'(e_cmd.size()), 0);
    chk(e_rsp.size() == 0, "R9", "pending responses", longint'(e_rsp.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule